// File: doc/BRIEF.md
# Repeating Single-Element DMA Channel

This block is one DMA channel engine. Each trigger, from a hardware strobe or from a software request bit, moves exactly one data element: a single read from the source pointer, then a single write of that data to the destination pointer. The memory side is a single-beat port with a ready handshake. A working count, a source pointer and a destination pointer are loaded from the configuration when the channel becomes active. Each pointer either steps by the element size or stays fixed.

The channel never shuts itself down. When the working count runs out, the count is restored to its configured value. Each pointer whose reload select is set returns to its configured start. A pointer whose reload select is clear keeps advancing. Half and done status flags and an interrupt flag are raised, and the channel waits for the next trigger. Software stops the sequence only by clearing the enable. A pair of global address limits fences every access. An access that would fall outside them is not issued and raises an address-error flag.

Top module: `rsdma_channel`

## Requirements
- R1: The channel services triggers only when `cfg_en` is 1 and `cfg_mode` equals 2'b01. Any other mode or a low enable issues no memory access. A rise of that active condition loads the working count from `cfg_count` and the pointers from `cfg_src` and `cfg_dst`.
- R2: Each serviced trigger produces one read (`mem_we`=0) at the source pointer, then one write (`mem_we`=1) at the destination pointer carrying the read data. `mem_size` equals `cfg_size`, and each request holds its address and direction until `mem_ready`.
- R3: Each completed transfer lowers the working count by one. At a count of one, the count reloads to `cfg_count` instead and the channel stays active for further triggers.
- R4: On count exhaustion, the source pointer returns to `cfg_src` when `cfg_src_rld` is 1, and the destination pointer returns to `cfg_dst` when `cfg_dst_rld` is 1. The two selects act independently. A pointer whose select is 0 keeps stepping from where it was.
- R5: A pointer with its increment bit set advances after each completed transfer by 1, 2 or 4 bytes for `cfg_size` 0, 1 or 2. Size 3 also steps by 4. A pointer with its increment bit clear stays fixed.
- R6: A pulse on `sw_req_set` sets `sw_req`, which acts as a trigger. The bit clears itself when its own transfer completes.
- R7: `stat_half` is set when a completed transfer leaves a remaining count equal to `cfg_count` shifted right by one (after 2 of 4).
- R8: `stat_done` and `irq` are set on count exhaustion. Flags are sticky until cleared through `stat_clr`: bit 0 clears half, bit 1 clears done, bit 2 clears irq, bit 3 clears the address error. A set in the same cycle wins over a clear.
- R9: A hardware trigger that arrives while a transfer is in progress is held, at most one deep, and serviced after the current transfer.
- R10: If either pointer lies outside [`lim_lo`, `lim_hi`] when a trigger is taken, the trigger is consumed without any memory access and without changing count or pointers, and `stat_addr_err` is set.
- R11: After reset every output is 0.
- R12: Clearing the enable drops held triggers and the software request, and further triggers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Channel enable |
| cfg_mode | input | 2 | Transfer mode, 2'b01 = repeating single-element |
| cfg_size | input | 2 | Element size: 0 byte, 1 halfword, 2 word |
| cfg_src_inc | input | 1 | Source pointer steps after each element |
| cfg_dst_inc | input | 1 | Destination pointer steps after each element |
| cfg_src_rld | input | 1 | Restore source pointer at count exhaustion |
| cfg_dst_rld | input | 1 | Restore destination pointer at count exhaustion |
| cfg_count | input | CW | Programmed element count (nonzero) |
| cfg_src | input | AW | Programmed source start |
| cfg_dst | input | AW | Programmed destination start |
| lim_lo | input | AW | Lowest legal address |
| lim_hi | input | AW | Highest legal address |
| hw_trig | input | 1 | Hardware trigger, one per high cycle |
| sw_req_set | input | 1 | Software write of 1 to the request bit |
| stat_clr | input | 4 | Flag clear strobes {addr_err, irq, done, half} |
| sw_req | output | 1 | Software request bit |
| stat_half | output | 1 | Halfway flag |
| stat_done | output | 1 | Count exhausted flag |
| stat_addr_err | output | 1 | Limit violation flag |
| irq | output | 1 | Channel interrupt flag |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Access address |
| mem_size | output | 2 | Access size |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with mem_ready on a read |
| mem_ready | input | 1 | Access accepted this cycle |

## Verification
The assertions take for granted that `cfg_count` is never zero. They also assume the configuration and the address limits stay still while the channel is enabled, since the count reload compares against the live `cfg_count` and the legality check against the live limits. The memory side is assumed to raise `mem_ready` only while `mem_req` is high. The bench keeps within this: it changes configuration only after dropping the enable, moves a limit only while the channel is idle, and its memory model derives ready from the request.

// File: rtl/rsdma_pkg.sv
// Shared definitions for the repeating single-element DMA channel.
// Assumes: element sizes 0/1/2 map to 1/2/4 bytes; code 3 is treated as 4.
package rsdma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } xfer_state_t;

    localparam logic [1:0] MODE_REPEAT_SINGLE = 2'b01;

    // Byte step for one element of the given size code.
    function automatic logic [2:0] elem_bytes(input logic [1:0] sz);
        case (sz)
            2'd0:    elem_bytes = 3'd1;
            2'd1:    elem_bytes = 3'd2;
            default: elem_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/rsdma_trig.sv
// Trigger capture for the channel: holds one hardware trigger and the
// software request bit, and remembers which of the two the current transfer
// serves. Hardware triggers take precedence when both are waiting.
// Assumes: take/reject/finish come from the channel sequencer; reject is
// only raised together with take.
module rsdma_trig (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic hw_trig,
    input  logic sw_set,
    input  logic take,
    input  logic reject,
    input  logic finish,
    output logic pending,
    output logic sw_req
);

    logic hw_pend_q;
    logic sw_q;
    logic serve_sw_q;
    logic take_hw;

    assign take_hw = take & hw_pend_q;
    assign pending = hw_pend_q | sw_q;
    assign sw_req  = sw_q;

    // Hold one hardware trigger; a new strobe wins over consumption.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hw_pend_q <= 1'b0;
        end else begin
            hw_pend_q <= active & ((hw_pend_q & ~take_hw) | hw_trig);
        end
    end

    // Record which request source the transfer being started serves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            serve_sw_q <= 1'b0;
        end else if (take) begin
            serve_sw_q <= ~hw_pend_q;
        end
    end

    // Software request bit: set by write, cleared when its transfer ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_q <= 1'b0;
        end else if (!active) begin
            sw_q <= 1'b0;
        end else if (sw_set) begin
            sw_q <= 1'b1;
        end else if ((finish & serve_sw_q) | (reject & ~hw_pend_q)) begin
            sw_q <= 1'b0;
        end
    end

    AST_SW_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && serve_sw_q && !sw_set) |=> !sw_q); // R6

    AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_pend_q && !take && active) |=> hw_pend_q); // R9

    AST_DISABLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (!sw_q && !hw_pend_q)); // R12

endmodule

// File: rtl/rsdma_count.sv
// Working element count with reload, plus the half, done and interrupt
// flags. The count reloads from the programmed value when the last element
// of a block completes.
// Assumes: cfg_count is nonzero and stable while the channel is active.
module rsdma_count #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] cfg_count,
    input  logic          finish,
    input  logic [2:0]    clr,
    output logic          last,
    output logic          half,
    output logic          done,
    output logic          irq
);

    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_next;
    logic          hit_half;
    logic          hit_done;

    assign last     = (cnt_q == ONE);
    assign cnt_next = cnt_q - ONE;
    assign hit_half = finish & (cnt_next == (cfg_count >> 1));
    assign hit_done = finish & last;

    // Load, decrement or reload the working count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= cfg_count;
        end else if (finish) begin
            cnt_q <= last ? cfg_count : cnt_next;
        end
    end

    // Sticky status flags; a set in the same cycle beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half <= 1'b0;
            done <= 1'b0;
            irq  <= 1'b0;
        end else begin
            half <= hit_half | (half & ~clr[0]);
            done <= hit_done | (done & ~clr[1]);
            irq  <= hit_done | (irq  & ~clr[2]);
        end
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && !last && !load) |=> cnt_q == $past(cnt_q) - ONE); // R3

    AST_CNT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && last && !load) |=> cnt_q == $past(cfg_count)); // R3

    AST_DONE_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && last) |=> (done && irq)); // R8

endmodule

// File: rtl/rsdma_ptr.sv
// One address pointer (source or destination): loads its start value,
// steps by the element size when incrementing, and returns to the start at
// count exhaustion when its reload select is set. Reports whether the
// current value lies inside the global limits.
// Assumes: AW is at least 4; limits are inclusive.
module rsdma_ptr
    import rsdma_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] start_val,
    input  logic          inc,
    input  logic          rld,
    input  logic [1:0]    size,
    input  logic          step,
    input  logic          wrap,
    input  logic [AW-1:0] lim_lo,
    input  logic [AW-1:0] lim_hi,
    output logic [AW-1:0] ptr,
    output logic          in_range
);

    localparam int PADW = AW - 3;

    logic [AW-1:0] ptr_q;
    logic [AW-1:0] stride;

    assign stride   = {{PADW{1'b0}}, elem_bytes(size)};
    assign ptr      = ptr_q;
    assign in_range = (ptr_q >= lim_lo) && (ptr_q <= lim_hi);

    // Load, reload or advance the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (load) begin
            ptr_q <= start_val;
        end else if (step) begin
            if (wrap && rld) begin
                ptr_q <= start_val;
            end else if (inc) begin
                ptr_q <= ptr_q + stride;
            end
        end
    end

    AST_PTR_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (step && wrap && rld && !load) |=> ptr_q == $past(start_val)); // R4

    AST_PTR_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !inc && !(wrap && rld) && !load) |=> $stable(ptr_q)); // R5

endmodule

// File: rtl/rsdma_channel.sv
// Top of the repeating single-element DMA channel. A three-state sequencer
// takes a pending trigger, checks both pointers against the limits, then
// issues one read and one write on the single-beat memory port. Completion
// steps the count and pointers and updates status.
// Assumes: configuration and limits only change while disabled or idle;
// mem_ready is only raised while mem_req is high.
module rsdma_channel
    import rsdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_en,
    input  logic [1:0]    cfg_mode,
    input  logic [1:0]    cfg_size,
    input  logic          cfg_src_inc,
    input  logic          cfg_dst_inc,
    input  logic          cfg_src_rld,
    input  logic          cfg_dst_rld,
    input  logic [CW-1:0] cfg_count,
    input  logic [AW-1:0] cfg_src,
    input  logic [AW-1:0] cfg_dst,
    input  logic [AW-1:0] lim_lo,
    input  logic [AW-1:0] lim_hi,
    input  logic          hw_trig,
    input  logic          sw_req_set,
    input  logic [3:0]    stat_clr,
    output logic          sw_req,
    output logic          stat_half,
    output logic          stat_done,
    output logic          stat_addr_err,
    output logic          irq,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_size,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready
);

    localparam int NPTR    = 2;
    localparam int IDX_SRC = 0;
    localparam int IDX_DST = 1;

    xfer_state_t state_q;
    logic        active;
    logic        active_q;
    logic        load;
    logic        pending;
    logic        take;
    logic        reject;
    logic        finish;
    logic        last;
    logic        all_ok;
    logic        err_q;
    logic [DW-1:0] data_q;

    logic [NPTR-1:0][AW-1:0] ptr_start;
    logic [NPTR-1:0][AW-1:0] ptr_val;
    logic [NPTR-1:0]         ptr_inc;
    logic [NPTR-1:0]         ptr_rld;
    logic [NPTR-1:0]         ptr_ok;

    assign active = cfg_en && (cfg_mode == MODE_REPEAT_SINGLE);
    assign load   = active & ~active_q;
    assign all_ok = &ptr_ok;
    assign take   = (state_q == ST_IDLE) && active && pending;
    assign reject = take && !all_ok;
    assign finish = (state_q == ST_WRITE) && mem_ready;

    assign ptr_start[IDX_SRC] = cfg_src;
    assign ptr_start[IDX_DST] = cfg_dst;
    assign ptr_inc[IDX_SRC]   = cfg_src_inc;
    assign ptr_inc[IDX_DST]   = cfg_dst_inc;
    assign ptr_rld[IDX_SRC]   = cfg_src_rld;
    assign ptr_rld[IDX_DST]   = cfg_dst_rld;

    // Edge detect of the active condition for loading working state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
        end else begin
            active_q <= active;
        end
    end

    // Sequencer: idle -> read -> write -> idle, one element per trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE:  if (take && all_ok) state_q <= ST_READ;
                ST_READ:  if (mem_ready) state_q <= ST_WRITE;
                ST_WRITE: if (mem_ready) state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Capture read data for the following write beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if ((state_q == ST_READ) && mem_ready) begin
            data_q <= mem_rdata;
        end
    end

    // Sticky address-error flag; a new violation beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= reject | (err_q & ~stat_clr[3]);
        end
    end

    // Memory port outputs decoded from the sequencer state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        mem_size  = 2'd0;
        case (state_q)
            ST_READ: begin
                mem_req  = 1'b1;
                mem_addr = ptr_val[IDX_SRC];
                mem_size = cfg_size;
            end
            ST_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ptr_val[IDX_DST];
                mem_wdata = data_q;
                mem_size  = cfg_size;
            end
            default: ;
        endcase
    end

    assign stat_addr_err = err_q;

    rsdma_trig u_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (active),
        .hw_trig (hw_trig),
        .sw_set  (sw_req_set),
        .take    (take),
        .reject  (reject),
        .finish  (finish),
        .pending (pending),
        .sw_req  (sw_req)
    );

    rsdma_count #(.CW(CW)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .cfg_count (cfg_count),
        .finish    (finish),
        .clr       (stat_clr[2:0]),
        .last      (last),
        .half      (stat_half),
        .done      (stat_done),
        .irq       (irq)
    );

    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        rsdma_ptr #(.AW(AW)) u_ptr (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (load),
            .start_val (ptr_start[g]),
            .inc       (ptr_inc[g]),
            .rld       (ptr_rld[g]),
            .size      (cfg_size),
            .step      (finish),
            .wrap      (finish & last),
            .lim_lo    (lim_lo),
            .lim_hi    (lim_hi),
            .ptr       (ptr_val[g]),
            .in_range  (ptr_ok[g])
        );
    end

    AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R2

    AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ready) |=> (mem_req && mem_we)); // R2

    AST_ACCESS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr >= lim_lo && mem_addr <= lim_hi)); // R10

    AST_WDATA_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ready) |=> mem_wdata == $past(mem_rdata)); // R2

endmodule

// File: tb/rsdma_channel_tb.sv
// Scoreboard bench: driver tasks push expected memory beats into a queue,
// a monitor pops and compares them at every accepted access.
module rsdma_channel_tb_top;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int CW = 16;

    typedef struct {
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [1:0]    size;
    } beat_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_en = 1'b0;
    logic [1:0]    cfg_mode = 2'd0;
    logic [1:0]    cfg_size = 2'd0;
    logic          cfg_src_inc = 1'b0;
    logic          cfg_dst_inc = 1'b0;
    logic          cfg_src_rld = 1'b0;
    logic          cfg_dst_rld = 1'b0;
    logic [CW-1:0] cfg_count = '0;
    logic [AW-1:0] cfg_src = '0;
    logic [AW-1:0] cfg_dst = '0;
    logic [AW-1:0] lim_lo = '0;
    logic [AW-1:0] lim_hi = '0;
    logic          hw_trig = 1'b0;
    logic          sw_req_set = 1'b0;
    logic [3:0]    stat_clr = '0;
    logic          sw_req, stat_half, stat_done, stat_addr_err, irq;
    logic          mem_req, mem_we, mem_ready;
    logic [AW-1:0] mem_addr;
    logic [1:0]    mem_size;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic          rdy_en = 1'b1;

    int n_chk = 0;
    int n_err = 0;
    int hs_cnt = 0;
    bit finished = 1'b0;
    beat_t expq[$];

    // model state
    logic [AW-1:0] m_src, m_dst, m_src0, m_dst0;
    int m_cnt, m_init, m_bytes;
    bit m_sinc, m_dinc, m_srld, m_drld, m_half, m_done;
    logic [1:0] m_size;

    always #5 clk = ~clk;

    function automatic logic [DW-1:0] patt(input logic [AW-1:0] a);
        return {~a[15:0], a[15:0]};
    endfunction

    assign mem_ready = mem_req & rdy_en;
    assign mem_rdata = mem_req ? patt(mem_addr) : '0;

    rsdma_channel #(.AW(AW), .DW(DW), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_mode(cfg_mode),
        .cfg_size(cfg_size), .cfg_src_inc(cfg_src_inc), .cfg_dst_inc(cfg_dst_inc),
        .cfg_src_rld(cfg_src_rld), .cfg_dst_rld(cfg_dst_rld), .cfg_count(cfg_count),
        .cfg_src(cfg_src), .cfg_dst(cfg_dst), .lim_lo(lim_lo), .lim_hi(lim_hi),
        .hw_trig(hw_trig), .sw_req_set(sw_req_set), .stat_clr(stat_clr),
        .sw_req(sw_req), .stat_half(stat_half), .stat_done(stat_done),
        .stat_addr_err(stat_addr_err), .irq(irq), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: every accepted beat must match the head of the queue.
    always @(negedge clk) begin
        if (rst_n && mem_req && mem_ready) begin
            hs_cnt++;
            if (expq.size() == 0) begin
                chk("R1/R10/R12", "unexpected access addr", mem_addr, 32'hFFFF_FFFF);
            end else begin
                beat_t e;
                e = expq.pop_front();
                chk("R2", "direction", {31'd0, mem_we}, {31'd0, e.we});
                chk("R5", "address", mem_addr, e.addr);
                chk("R2", "size", {30'd0, mem_size}, {30'd0, e.size});
                if (e.we) chk("R2", "write data", mem_wdata, e.data);
            end
        end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clear_flags();
        @(negedge clk);
        stat_clr = 4'hF;
        @(negedge clk);
        stat_clr = 4'h0;
        m_half = 0;
        m_done = 0;
    endtask

    task automatic configure(input logic [1:0] mode, input logic [1:0] size,
                             input bit sinc, input bit dinc, input bit srld, input bit drld,
                             input int count, input logic [AW-1:0] src, input logic [AW-1:0] dst);
        @(negedge clk);
        cfg_en = 1'b0;
        @(negedge clk);
        cfg_mode = mode; cfg_size = size;
        cfg_src_inc = sinc; cfg_dst_inc = dinc;
        cfg_src_rld = srld; cfg_dst_rld = drld;
        cfg_count = CW'(count); cfg_src = src; cfg_dst = dst;
        cfg_en = 1'b1;
        m_src = src; m_dst = dst; m_src0 = src; m_dst0 = dst;
        m_cnt = count; m_init = count; m_size = size;
        m_bytes = (size == 2'd0) ? 1 : (size == 2'd1) ? 2 : 4;
        m_sinc = sinc; m_dinc = dinc; m_srld = srld; m_drld = drld;
        cycles(2);
        clear_flags();
    endtask

    // Driver: push the beats one trigger must produce, then advance the model.
    task automatic expect_xfer();
        bit wrap;
        expq.push_back('{we: 1'b0, addr: m_src, data: patt(m_src), size: m_size});
        expq.push_back('{we: 1'b1, addr: m_dst, data: patt(m_src), size: m_size});
        m_cnt--;
        wrap = (m_cnt == 0);
        if (wrap) m_cnt = m_init;
        if (!wrap && m_cnt == (m_init >> 1)) m_half = 1;
        if (wrap && (m_init >> 1) == 0) m_half = 1;
        if (wrap) m_done = 1;
        if (wrap && m_srld) m_src = m_src0; else if (m_sinc) m_src = m_src + AW'(m_bytes);
        if (wrap && m_drld) m_dst = m_dst0; else if (m_dinc) m_dst = m_dst + AW'(m_bytes);
    endtask

    task automatic pulse_hw();
        @(negedge clk);
        hw_trig = 1'b1;
        @(negedge clk);
        hw_trig = 1'b0;
    endtask

    task automatic check_flags(input string tag);
        chk("R7", {tag, " half"}, {31'd0, stat_half}, {31'd0, m_half});
        chk("R8", {tag, " done"}, {31'd0, stat_done}, {31'd0, m_done});
        chk("R8", {tag, " irq"}, {31'd0, irq}, {31'd0, m_done});
        chk("R3", {tag, " beats drained"}, expq.size(), 0);
    endtask

    task automatic hw_shot(input string tag);
        expect_xfer();
        pulse_hw();
        cycles(8);
        check_flags(tag);
    endtask

    task automatic sw_shot(input string tag);
        expect_xfer();
        @(negedge clk);
        sw_req_set = 1'b1;
        @(negedge clk);
        sw_req_set = 1'b0;
        chk("R6", {tag, " request bit set"}, {31'd0, sw_req}, 32'd1);
        cycles(8);
        chk("R6", {tag, " request bit self-cleared"}, {31'd0, sw_req}, 32'd0);
        check_flags(tag);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int hs0;
        cycles(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk("R11", "mem_req", {31'd0, mem_req}, 32'd0);
        chk("R11", "flags", {27'd0, sw_req, stat_half, stat_done, stat_addr_err, irq}, 32'd0);

        lim_lo = 32'h100;
        lim_hi = 32'h2FF;

        // R1: wrong mode issues nothing and ignores the software bit
        configure(2'b00, 2'd2, 1, 1, 1, 1, 4, 32'h100, 32'h200);
        hs0 = hs_cnt;
        pulse_hw();
        @(negedge clk);
        sw_req_set = 1'b1;
        @(negedge clk);
        sw_req_set = 1'b0;
        cycles(8);
        chk("R1", "accesses in other mode", hs_cnt - hs0, 0);
        chk("R1", "sw bit in other mode", {31'd0, sw_req}, 32'd0);

        // R3 R7 R8 R4: word elements, both reloads, count of four
        configure(2'b01, 2'd2, 1, 1, 1, 1, 4, 32'h100, 32'h200);
        hw_shot("blk1 e1");
        hw_shot("blk1 e2");
        chk("R7", "half after 2 of 4", {31'd0, stat_half}, 32'd1);
        hw_shot("blk1 e3");
        hw_shot("blk1 e4");
        chk("R8", "done after 4 of 4", {31'd0, stat_done}, 32'd1);
        hw_shot("blk2 e1 after reload");
        clear_flags();
        chk("R8", "flags cleared", {29'd0, stat_half, stat_done, irq}, 32'd0);

        // R6: software requests
        sw_shot("sw a");
        sw_shot("sw b");

        // R5 R4: byte elements, destination fixed, no reload
        configure(2'b01, 2'd0, 1, 0, 0, 0, 2, 32'h120, 32'h280);
        hw_shot("byte e1");
        hw_shot("byte e2");
        hw_shot("byte e3 source keeps stepping");

        // R4 R5: halfword, source reloads, destination continues
        configure(2'b01, 2'd1, 1, 1, 1, 0, 3, 32'h140, 32'h180);
        hw_shot("half e1");
        hw_shot("half e2");
        hw_shot("half e3");
        hw_shot("half e4 independent reload");

        // R9: trigger during a stalled transfer is held and served
        @(negedge clk);
        rdy_en = 1'b0;
        hs0 = hs_cnt;
        expect_xfer();
        expect_xfer();
        pulse_hw();
        cycles(3);
        pulse_hw();
        cycles(3);
        chk("R9", "no beat while stalled", hs_cnt - hs0, 0);
        rdy_en = 1'b1;
        cycles(14);
        chk("R9", "held trigger served", hs_cnt - hs0, 4);
        check_flags("pending");

        // R10: destination out of limits consumes a software request
        configure(2'b01, 2'd2, 1, 1, 0, 0, 2, 32'h100, 32'h300);
        hs0 = hs_cnt;
        @(negedge clk);
        sw_req_set = 1'b1;
        @(negedge clk);
        sw_req_set = 1'b0;
        cycles(8);
        chk("R10", "no access out of limits", hs_cnt - hs0, 0);
        chk("R10", "address error flag", {31'd0, stat_addr_err}, 32'd1);
        chk("R10", "request consumed", {31'd0, sw_req}, 32'd0);
        @(negedge clk);
        lim_hi = 32'h3FF;
        hw_shot("after limit fix count unchanged");
        chk("R10", "half shows count was unchanged", {31'd0, stat_half}, 32'd1);
        @(negedge clk);
        stat_clr = 4'h8;
        @(negedge clk);
        stat_clr = 4'h0;
        chk("R8", "address error cleared by bit 3", {31'd0, stat_addr_err}, 32'd0);

        // R12: disabled channel ignores triggers
        @(negedge clk);
        cfg_en = 1'b0;
        hs0 = hs_cnt;
        pulse_hw();
        @(negedge clk);
        sw_req_set = 1'b1;
        @(negedge clk);
        sw_req_set = 1'b0;
        cycles(8);
        chk("R12", "no access when disabled", hs_cnt - hs0, 0);
        chk("R12", "sw bit ignored when disabled", {31'd0, sw_req}, 32'd0);

        chk("R2", "all expected beats seen", expq.size(), 0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule